// File: doc/BRIEF.md
# Circular and Reverse-Carry Data Address Generator

This block computes the next effective byte address for one data space. The memory behind it holds 16-bit words and is addressed by byte. Each request carries the current pointer and its access attributes. The generator returns the post-modified pointer through a single registered stage. Word accesses step by two bytes and byte accesses step by one. The pointer can move upward or downward.

Three ways of forming the next pointer are available:
- **Linear:** plain linear stepping.
- **Circular:** a buffer whose lower and upper limits are programmed. The pointer reloads automatically when it leaves the buffer, so a loop needs no software wrap check.
- **Reverse-carry:** a walk over the low log2(N) word-index bits that produces the bit-reversed order used by radix-2 FFT reordering.

Reverse-carry stepping exists only in the instance built for the primary (X) space, and it applies only to destination accesses. The instance for the secondary (Y) space is built with that feature removed. Each space has its own instance, and the split between the spaces is fixed outside this block.

Requests enter on a valid/ready handshake, and results leave on another. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its result appears with `addr_valid` high after that edge. While `addr_valid` is high and `addr_ready` is low, the result is held unchanged and `req_ready` is low. This means no request is lost and no result is overwritten. Configuration pins are plain levels, sampled with each accepted request.

Top module: `agu_addr_gen`

## Requirements
- R1: After reset, `addr_valid` is low and `req_ready` is high.
- R2: In linear mode the result is the pointer plus or minus the step (2 when `req_byte` is 0, 1 when it is 1, with `req_down`=1 meaning decrement). The result wraps modulo 2^16.
- R3: In circular mode (`cfg_circ_en`=1), an upward step whose result would exceed `cfg_hi` (the inclusive address of the last element) yields `cfg_lo`.
- R4: In circular mode, a downward step whose result would fall below `cfg_lo` yields `cfg_hi`.
- R5: In circular mode, a step whose result stays within [`cfg_lo`, `cfg_hi`] yields the same value as linear mode.
- R6: In reverse-carry mode, with L the effective log2 of the FFT size, bits L down to 1 of the pointer are incremented with the carry running from bit L toward bit 1. Bits above L are kept, and bit 0 of the result is 0.
- R7: In reverse-carry mode, `req_down` and `req_byte` have no effect on the result.
- R8: Reverse-carry mode applies only when `req_dst` is 1. Source accesses with `cfg_rev_en`=1 follow circular or linear rules.
- R9: When reverse-carry and circular modes are both enabled for a destination access, reverse-carry stepping is used.
- R10: `cfg_log2n` selects N from 2 to 1024. A value of 0 acts as 1, and a value above 10 acts as 10.
- R11: While `addr_valid` is high and `addr_ready` is low, `addr_next` stays stable and `req_ready` is low.
- R12: An instance built without reverse-carry support (parameter `HAS_REV`=0) ignores `cfg_rev_en` and `cfg_log2n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_ptr | input | 16 | Current pointer (byte address) |
| req_down | input | 1 | 1 = post-decrement, 0 = post-increment |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_dst | input | 1 | 1 = destination effective address |
| cfg_circ_en | input | 1 | Circular buffer enable |
| cfg_lo | input | 16 | Circular buffer lower limit (inclusive) |
| cfg_hi | input | 16 | Circular buffer upper limit (inclusive, last element) |
| cfg_rev_en | input | 1 | Reverse-carry enable |
| cfg_log2n | input | 4 | log2 of FFT size |
| addr_valid | output | 1 | Result present |
| addr_ready | input | 1 | Consumer takes the result |
| addr_next | output | 16 | Post-modified pointer |

## Verification
A fault in the circular compare shows up in the first result whose step crosses a limit. The pointer either leaves the buffer or reloads to the wrong end, and this is visible one cycle after acceptance. A wrong carry direction or width in the reverse-carry adder corrupts the index bits of the very next result, or bit 0 ends up set. Wrong stall handling shows up within one cycle of `addr_ready` going low. It appears as a changed held address or as a request accepted while the output is full.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int AGU_AW   = 16;
  localparam int AGU_MAXL = 10;
  localparam int AGU_LW   = 4;

  typedef enum logic [1:0] {
    STEP_LINEAR = 2'd0,
    STEP_CIRC   = 2'd1,
    STEP_REV    = 2'd2
  } step_kind_e;
endpackage

// File: rtl/agu_circ_step.sv
module agu_circ_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic          down,
  input  logic          bytesz,
  input  logic          circ_en,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW-1:0] nxt
);
  logic [AW:0] step;
  logic [AW:0] up_sum;
  logic [AW:0] dn_dif;
  logic        over_hi;
  logic        under_lo;

  always_comb begin
    step     = bytesz ? (AW+1)'(1) : (AW+1)'(2);
    up_sum   = {1'b0, ptr} + step;
    dn_dif   = {1'b0, ptr} - step;
    over_hi  = up_sum > {1'b0, hi};
    under_lo = {1'b0, ptr} < ({1'b0, lo} + step);
    if (!down) nxt = (circ_en && over_hi) ? lo : up_sum[AW-1:0];
    else       nxt = (circ_en && under_lo) ? hi : dn_dif[AW-1:0];
  end
endmodule

// File: rtl/agu_rev_step.sv
module agu_rev_step #(
  parameter int AW   = 16,
  parameter int MAXL = 10,
  parameter int LW   = 4
) (
  input  logic [AW-1:0] ptr,
  input  logic [LW-1:0] log2n,
  output logic [AW-1:0] nxt
);
  logic [LW-1:0] eff_l;
  logic          carry;

  always_comb begin
    if (log2n == '0)                 eff_l = LW'(1);
    else if (int'(log2n) > MAXL)     eff_l = LW'(MAXL);
    else                             eff_l = log2n;
    nxt   = ptr;
    nxt[0] = 1'b0;
    carry = 1'b1;
    for (int k = 0; k < MAXL; k++) begin
      if (k < int'(eff_l)) begin
        nxt[int'(eff_l) - k] = ptr[int'(eff_l) - k] ^ carry;
        carry                = ptr[int'(eff_l) - k] & carry;
      end
    end
  end
endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_addr <= in_addr;
    end
  end
endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen
  import agu_pkg::*;
#(
  parameter int AW      = AGU_AW,
  parameter int MAXL    = AGU_MAXL,
  parameter int LW      = AGU_LW,
  parameter bit HAS_REV = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_ptr,
  input  logic          req_down,
  input  logic          req_byte,
  input  logic          req_dst,
  input  logic          cfg_circ_en,
  input  logic [AW-1:0] cfg_lo,
  input  logic [AW-1:0] cfg_hi,
  input  logic          cfg_rev_en,
  input  logic [LW-1:0] cfg_log2n,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr_next
);
  logic [AW-1:0] circ_addr;
  logic [AW-1:0] rev_addr;
  logic [AW-1:0] sel_addr;
  step_kind_e    kind;

  agu_circ_step #(.AW(AW)) u_circ (
    .ptr(req_ptr), .down(req_down), .bytesz(req_byte), .circ_en(cfg_circ_en),
    .lo(cfg_lo), .hi(cfg_hi), .nxt(circ_addr)
  );

  generate
    if (HAS_REV) begin : g_rev
      agu_rev_step #(.AW(AW), .MAXL(MAXL), .LW(LW)) u_rev (
        .ptr(req_ptr), .log2n(cfg_log2n), .nxt(rev_addr)
      );
      always_comb begin
        if (cfg_rev_en && req_dst) kind = STEP_REV;
        else if (cfg_circ_en)      kind = STEP_CIRC;
        else                       kind = STEP_LINEAR;
      end
    end else begin : g_norev
      assign rev_addr = '0;
      always_comb kind = cfg_circ_en ? STEP_CIRC : STEP_LINEAR;
    end
  endgenerate

  always_comb begin
    sel_addr = (kind == STEP_REV) ? rev_addr : circ_addr;
  end

  agu_out_stage #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_addr(sel_addr),
    .out_valid(addr_valid), .out_ready(addr_ready), .out_addr(addr_next)
  );
endmodule

// File: rtl/agu_addr_gen_chk.sv
module agu_addr_gen_chk #(
  parameter int AW      = 16,
  parameter bit HAS_REV = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_ptr,
  input logic          req_down,
  input logic          req_byte,
  input logic          req_dst,
  input logic          cfg_circ_en,
  input logic [AW-1:0] cfg_lo,
  input logic [AW-1:0] cfg_hi,
  input logic          cfg_rev_en,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr_next
);
  logic acc;
  logic rev_sel;
  logic circ_in;
  assign acc     = req_valid && req_ready;
  assign rev_sel = HAS_REV && cfg_rev_en && req_dst;
  assign circ_in = cfg_circ_en && !rev_sel && (cfg_lo <= cfg_hi) &&
                   (req_ptr >= cfg_lo) && (req_ptr <= cfg_hi);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_next)));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |-> !req_ready);

  // R6
  rev_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rev_sel) |=> (addr_valid && !addr_next[0]));

  // R3
  circ_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && circ_in) |=> (addr_next >= $past(cfg_lo) && addr_next <= $past(cfg_hi)));

  // R2
  lin_up_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cfg_circ_en && !rev_sel && !req_down && !req_byte)
      |=> (addr_next == AW'($past(req_ptr) + AW'(2))));
endmodule

bind agu_addr_gen agu_addr_gen_chk #(.AW(AW), .HAS_REV(HAS_REV)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_ptr(req_ptr), .req_down(req_down), .req_byte(req_byte), .req_dst(req_dst),
  .cfg_circ_en(cfg_circ_en), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_rev_en(cfg_rev_en),
  .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_next(addr_next)
);

// File: tb/agu_addr_gen_tb.sv
module agu_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_ptr = '0;
  logic        req_down = 1'b0, req_byte = 1'b0, req_dst = 1'b0;
  logic        cfg_circ_en = 1'b0, cfg_rev_en = 1'b0;
  logic [15:0] cfg_lo = '0, cfg_hi = '0;
  logic [3:0]  cfg_log2n = 4'd1;
  logic        addr_ready = 1'b1;
  logic        x_req_ready, x_addr_valid, y_req_ready, y_addr_valid;
  logic [15:0] x_addr, y_addr;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  agu_addr_gen #(.HAS_REV(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(x_req_ready),
    .req_ptr(req_ptr), .req_down(req_down), .req_byte(req_byte), .req_dst(req_dst),
    .cfg_circ_en(cfg_circ_en), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_rev_en(cfg_rev_en), .cfg_log2n(cfg_log2n),
    .addr_valid(x_addr_valid), .addr_ready(addr_ready), .addr_next(x_addr)
  );

  agu_addr_gen #(.HAS_REV(1'b0)) u_dut_y (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(y_req_ready),
    .req_ptr(req_ptr), .req_down(req_down), .req_byte(req_byte), .req_dst(req_dst),
    .cfg_circ_en(cfg_circ_en), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_rev_en(cfg_rev_en), .cfg_log2n(cfg_log2n),
    .addr_valid(y_addr_valid), .addr_ready(addr_ready), .addr_next(y_addr)
  );

  function automatic logic [15:0] model(input logic [15:0] p, input logic dn,
      input logic by, input logic dst, input logic ce, input logic [15:0] lo,
      input logic [15:0] hi, input logic re, input logic [3:0] l2, input bit has_rev);
    int s, v, l;
    logic [15:0] r;
    int idx, rev, rev2;
    if (has_rev && re && dst) begin
      l = (l2 == 0) ? 1 : ((l2 > 10) ? 10 : int'(l2));
      idx = int'(p >> 1) & ((1 << l) - 1);
      rev = 0;
      for (int i = 0; i < l; i++) if (idx[i]) rev |= 1 << (l - 1 - i);
      rev = (rev + 1) & ((1 << l) - 1);
      rev2 = 0;
      for (int i = 0; i < l; i++) if (rev[i]) rev2 |= 1 << (l - 1 - i);
      r = (p & ~16'(((1 << l) - 1) << 1)) | 16'(rev2 << 1);
      r[0] = 1'b0;
      return r;
    end
    s = by ? 1 : 2;
    v = dn ? int'(p) - s : int'(p) + s;
    if (ce && !dn && v > int'(hi)) return lo;
    if (ce && dn && v < int'(lo))  return hi;
    return 16'(v);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [15:0] p, input logic dn,
      input logic by, input logic dst, input logic ce, input logic [15:0] lo,
      input logic [15:0] hi, input logic re, input logic [3:0] l2);
    @(negedge clk);
    req_ptr = p; req_down = dn; req_byte = by; req_dst = dst;
    cfg_circ_en = ce; cfg_lo = lo; cfg_hi = hi; cfg_rev_en = re; cfg_log2n = l2;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, {15'd0, x_addr_valid & y_addr_valid}, 16'd1);
    check({tag, " X"}, x_addr, model(p, dn, by, dst, ce, lo, hi, re, l2, 1'b1));
    check({tag, " Y R12"}, y_addr, model(p, dn, by, dst, ce, lo, hi, re, l2, 1'b0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 addr_valid", {15'd0, x_addr_valid}, 16'd0);
    check("R1 req_ready", {15'd0, x_req_ready}, 16'd1);
    rst_n = 1'b1;

    // R2 linear
    send("R2 up word", 16'h1000, 0, 0, 0, 0, 0, 0, 0, 1);
    send("R2 down byte", 16'h1000, 1, 1, 0, 0, 0, 0, 0, 1);
    send("R2 wrap down", 16'h0000, 1, 0, 0, 0, 0, 0, 0, 1);
    send("R2 wrap up", 16'hFFFF, 0, 1, 0, 0, 0, 0, 0, 1);
    // R3 R4 R5 circular
    send("R3 past hi", 16'h201E, 0, 0, 0, 1, 16'h2000, 16'h201E, 0, 1);
    send("R4 below lo", 16'h2000, 1, 0, 0, 1, 16'h2000, 16'h201E, 0, 1);
    send("R5 inside", 16'h2010, 0, 0, 0, 1, 16'h2000, 16'h201E, 0, 1);
    send("R4 byte below", 16'h2000, 1, 1, 0, 1, 16'h2000, 16'h2007, 0, 1);
    // R6 reverse-carry, N=8 (L=3)
    send("R6 idx0", 16'h4000, 0, 0, 1, 0, 0, 0, 1, 3);
    send("R6 idx4", 16'h4008, 0, 0, 1, 0, 0, 0, 1, 3);
    send("R6 idx7 wrap", 16'h400E, 0, 0, 1, 0, 0, 0, 1, 3);
    send("R6 odd ptr", 16'h4003, 0, 0, 1, 0, 0, 0, 1, 3);
    // R7 direction and size ignored
    send("R7 down byte", 16'h4008, 1, 1, 1, 0, 0, 0, 1, 3);
    // R8 source access
    send("R8 source", 16'h4008, 0, 0, 0, 0, 0, 0, 1, 3);
    // R9 precedence
    send("R9 both", 16'h201E, 0, 0, 1, 1, 16'h2000, 16'h201E, 1, 4);
    // R10 clamp
    send("R10 zero", 16'h0002, 0, 0, 1, 0, 0, 0, 1, 0);
    send("R10 big", 16'h0400, 0, 0, 1, 0, 0, 0, 1, 15);
    send("R10 max", 16'h07FE, 0, 0, 1, 0, 0, 0, 1, 10);

    // R11 back-pressure
    @(negedge clk);
    addr_ready = 1'b0;
    req_ptr = 16'h3000; req_down = 0; req_byte = 0; req_dst = 0;
    cfg_circ_en = 0; cfg_rev_en = 0; req_valid = 1'b1;
    @(negedge clk);
    req_ptr = 16'h5000;
    check("R11 ready low", {15'd0, x_req_ready}, 16'd0);
    check("R11 first", x_addr, 16'h3002);
    @(negedge clk);
    check("R11 held", x_addr, 16'h3002);
    check("R11 still valid", {15'd0, x_addr_valid}, 16'd1);
    addr_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 second", x_addr, 16'h5002);
    @(negedge clk);
    check("R11 drained", {15'd0, x_addr_valid}, 16'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] lo, hi, p;
      logic ce, re, dst, dn, by;
      logic [3:0] l2;
      lo = 16'($urandom_range(0, 16'h7000)) & 16'hFFFE;
      hi = lo + 16'(2 * $urandom_range(0, 40));
      p  = lo + 16'($urandom_range(0, int'(hi - lo)));
      ce = 1'($urandom); re = 1'($urandom); dst = 1'($urandom);
      dn = 1'($urandom); by = 1'($urandom);
      l2 = 4'($urandom_range(0, 15));
      send("R5 R9 random", p, dn, by, dst, ce, lo, hi, re, l2);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule